// File: doc/BRIEF.md
# Comparator Control and Status Register File

This block is the byte-wide register file that sits beside an analog comparator. It gives software six 8-bit registers. They configure the comparator's output filter, main control bits, filter sampling period, DAC level and input multiplexer. A status register reports the comparator's current output level and two sticky edge flags. The register port is synchronous. A write takes effect at the rising clock edge on which `wr_en` is high. Reads are combinational from `addr`.

The comparator output from the filter datapath enters on `cmp_in`. A two-state edge tracker follows the level of that signal.
- State `ST_LOW` means the last sampled level was 0, and `ST_HIGH` means it was 1.
- The transition `RISE_SEEN` (`ST_LOW` to `ST_HIGH`) fires when a 1 is sampled in `ST_LOW`. It sets the rising flag.
- The transition `FALL_SEEN` (`ST_HIGH` to `ST_LOW`) fires when a 0 is sampled in `ST_HIGH`. It sets the falling flag.
- In any other cycle the tracker holds its state.

The flags drive a registered interrupt and a combinational DMA request. The file resolves a write that requests both external sampling and windowing. It also reports an effective comparator enable, which is forced low whenever both mux selects pick the same input.

Register offsets:
- 0: filter control.
- 1: main control.
- 2: filter period.
- 3: status.
- 4: DAC control.
- 5: mux control.
- 6 and 7: unmapped.

Top module: `cmp_regs_top`

## Requirements
- R1: After reset every offset reads 0x00, and `irq`, `dma_req` and `core_en` are 0.
- R2: Main control (offset 1) stores bit 0 enable, bit 1 pin enable, bit 2 output path, bit 3 invert, bit 4 power mode, bit 6 windowing and bit 7 sampling. A write with both bit 7 and bit 6 set stores bit 7 = 1 and bit 6 = 0. Bit 6 alone is kept.
- R3: Reserved bits read 0 and ignore writes. The writable masks are:
  - offset 0: 0x73
  - offset 1: 0xDF
  - offset 3: 0x58 for its read/write bits
  - offset 5: 0xBF
  - offsets 2 and 4: all 8 bits

  Offsets 6 and 7 always read 0x00.
- R4: Status bit 0 reads the comparator level sampled at the latest clock edge, and writes to it are ignored.
- R5: A 0-to-1 change of the sampled level sets status bit 2 (rising flag). A 1-to-0 change sets status bit 1 (falling flag). The flags stay set until cleared.
- R6: Writing 1 to status bit 1 or bit 2 clears that flag, and writing 0 leaves it unchanged. An edge and a clear that reach the same flag in the same cycle leave it set.
- R7: `irq` is registered. It equals, one cycle later, (falling flag AND status bit 3) OR (rising flag AND status bit 4).
- R8: `dma_req` is high exactly while status bit 6 is set and at least one edge flag is set.
- R9: `core_en` equals main control bit 0 AND (mux bits [2:0] differ from mux bits [5:3]). Mux bit 7 is the pass-through enable.
- R10: DAC control (offset 4: code [5:0], reference select bit 6, enable bit 7) and filter period (offset 2) read back the full byte written. Each register is also presented on its own output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| cmp_in | input | 1 | Comparator output from the filter datapath |
| filt_ctrl_o | output | 8 | Filter control register |
| main_ctrl_o | output | 8 | Main control register |
| filt_per_o | output | 8 | Filter period register |
| dac_ctrl_o | output | 8 | DAC control register |
| mux_ctrl_o | output | 8 | Mux control register |
| core_en | output | 1 | Effective comparator enable |
| irq | output | 1 | Registered edge interrupt |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with the package defaults: 8-bit data, a 3-bit offset and 3-bit mux selects. With these values every mapped and unmapped offset can be written with 0xFF and read back in a single sweep. The two mux selects can be driven equal at their all-ones code. Directed scenarios also reach the cycle on which a falling edge and a write-one-to-clear meet on the same flag. They check the one-cycle lag of the interrupt behind its flag, on both set and clear.

// File: rtl/cmp_regs_pkg.sv
package cmp_regs_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int SEL_W  = 3;

    localparam logic [ADDR_W-1:0] OFF_FILT = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_MAIN = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_PER  = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_DAC  = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_MUX  = 3'd5;

    localparam logic [DATA_W-1:0] MASK_FILT = 8'h73;
    localparam logic [DATA_W-1:0] MASK_MAIN = 8'hDF;
    localparam logic [DATA_W-1:0] MASK_STAT = 8'h58;
    localparam logic [DATA_W-1:0] MASK_MUX  = 8'hBF;

    // bit positions that neighbouring logic decodes
    localparam int MAIN_EN_BIT  = 0;
    localparam int MAIN_WIN_BIT = 6;
    localparam int MAIN_SMP_BIT = 7;
    localparam int STAT_LVL_BIT = 0;
    localparam int STAT_FF_BIT  = 1;
    localparam int STAT_FR_BIT  = 2;
    localparam int STAT_IEF_BIT = 3;
    localparam int STAT_IER_BIT = 4;
    localparam int STAT_DMA_BIT = 6;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } lvl_state_t;
endpackage

// File: rtl/cmp_edge_fsm.sv
module cmp_edge_fsm
    import cmp_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    lvl_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:  if (cmp_i)  state_d = ST_HIGH;  // RISE_SEEN
            ST_HIGH: if (!cmp_i) state_d = ST_LOW;   // FALL_SEEN
            default: state_d = ST_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        level_o = (state_q == ST_HIGH);
        rise_o  = (state_q == ST_LOW)  &&  cmp_i;
        fall_o  = (state_q == ST_HIGH) && !cmp_i;
    end
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic fall_i,
    input  logic clr_rise_i,
    input  logic clr_fall_i,
    input  logic ie_rise_i,
    input  logic ie_fall_i,
    input  logic dma_en_i,
    output logic flag_rise_o,
    output logic flag_fall_o,
    output logic irq_o,
    output logic dma_o
);
    logic fr_q, ff_q, irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q  <= 1'b0;
            ff_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            // set has priority over a same-cycle clear
            fr_q  <= rise_i | (fr_q & ~clr_rise_i);
            ff_q  <= fall_i | (ff_q & ~clr_fall_i);
            irq_q <= (ff_q & ie_fall_i) | (fr_q & ie_rise_i);
        end
    end

    always_comb begin
        flag_rise_o = fr_q;
        flag_fall_o = ff_q;
        irq_o       = irq_q;
        dma_o       = dma_en_i & (fr_q | ff_q);
    end
endmodule

// File: rtl/cmp_regs_top.sv
module cmp_regs_top
    import cmp_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cmp_in,
    output logic [DATA_W-1:0] filt_ctrl_o,
    output logic [DATA_W-1:0] main_ctrl_o,
    output logic [DATA_W-1:0] filt_per_o,
    output logic [DATA_W-1:0] dac_ctrl_o,
    output logic [DATA_W-1:0] mux_ctrl_o,
    output logic              core_en,
    output logic              irq,
    output logic              dma_req
);
    logic [DATA_W-1:0] filt_q, main_q, per_q, stat_q, dac_q, mux_q;
    logic [DATA_W-1:0] main_wd;
    logic              level, rise, fall, flag_r, flag_f;
    logic              stat_wr;

    always_comb begin
        main_wd = wdata & MASK_MAIN;
        if (main_wd[MAIN_SMP_BIT]) main_wd[MAIN_WIN_BIT] = 1'b0;
    end

    assign stat_wr = wr_en && (addr == OFF_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= '0;
            main_q <= '0;
            per_q  <= '0;
            stat_q <= '0;
            dac_q  <= '0;
            mux_q  <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFF_FILT: filt_q <= wdata & MASK_FILT;
                OFF_MAIN: main_q <= main_wd;
                OFF_PER:  per_q  <= wdata;
                OFF_STAT: stat_q <= wdata & MASK_STAT;
                OFF_DAC:  dac_q  <= wdata;
                OFF_MUX:  mux_q  <= wdata & MASK_MUX;
                default:  ;
            endcase
        end
    end

    cmp_edge_fsm u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_i   (cmp_in),
        .level_o (level),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    cmp_flag_unit u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .fall_i      (fall),
        .clr_rise_i  (stat_wr && wdata[STAT_FR_BIT]),
        .clr_fall_i  (stat_wr && wdata[STAT_FF_BIT]),
        .ie_rise_i   (stat_q[STAT_IER_BIT]),
        .ie_fall_i   (stat_q[STAT_IEF_BIT]),
        .dma_en_i    (stat_q[STAT_DMA_BIT]),
        .flag_rise_o (flag_r),
        .flag_fall_o (flag_f),
        .irq_o       (irq),
        .dma_o       (dma_req)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_FILT: rdata = filt_q;
            OFF_MAIN: rdata = main_q;
            OFF_PER:  rdata = per_q;
            OFF_STAT: begin
                rdata               = stat_q;
                rdata[STAT_LVL_BIT] = level;
                rdata[STAT_FF_BIT]  = flag_f;
                rdata[STAT_FR_BIT]  = flag_r;
            end
            OFF_DAC:  rdata = dac_q;
            OFF_MUX:  rdata = mux_q;
            default:  rdata = '0;
        endcase
    end

    assign filt_ctrl_o = filt_q;
    assign main_ctrl_o = main_q;
    assign filt_per_o  = per_q;
    assign dac_ctrl_o  = dac_q;
    assign mux_ctrl_o  = mux_q;
    assign core_en     = main_q[MAIN_EN_BIT] &&
                         (mux_q[SEL_W-1:0] != mux_q[2*SEL_W-1:SEL_W]);
endmodule

// File: rtl/cmp_regs_chk.sv
module cmp_regs_chk
    import cmp_regs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] main_q,
    input logic [DATA_W-1:0] mux_q,
    input logic [DATA_W-1:0] stat_q,
    input logic              level,
    input logic              flag_r,
    input logic              flag_f,
    input logic              irq,
    input logic              dma_req,
    input logic              core_en
);
    AST_SMP_WIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_q[MAIN_SMP_BIT] && main_q[MAIN_WIN_BIT]));  // R2

    AST_RISE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level) |-> flag_r);  // R5

    AST_FALL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level) |-> flag_f);  // R5

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_f && stat_q[STAT_IEF_BIT]) || (flag_r && stat_q[STAT_IER_BIT])) |=> irq);  // R7

    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !((flag_f && stat_q[STAT_IEF_BIT]) || (flag_r && stat_q[STAT_IER_BIT])) |=> !irq);  // R7

    AST_DMA_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (stat_q[STAT_DMA_BIT] && (flag_r || flag_f)));  // R8

    AST_MUX_SAME_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_q[SEL_W-1:0] == mux_q[2*SEL_W-1:SEL_W]) |-> !core_en);  // R9
endmodule

bind cmp_regs_top cmp_regs_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .main_q  (main_q),
    .mux_q   (mux_q),
    .stat_q  (stat_q),
    .level   (level),
    .flag_r  (flag_r),
    .flag_f  (flag_f),
    .irq     (irq),
    .dma_req (dma_req),
    .core_en (core_en)
);

// File: tb/cmp_regs_top_tb_top.sv
module cmp_regs_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cmp_in = 1'b0;
    logic [7:0] filt_ctrl_o, main_ctrl_o, filt_per_o, dac_ctrl_o, mux_ctrl_o;
    logic       core_en, irq, dma_req;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    cmp_regs_top dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .cmp_in(cmp_in), .filt_ctrl_o(filt_ctrl_o),
        .main_ctrl_o(main_ctrl_o), .filt_per_o(filt_per_o), .dac_ctrl_o(dac_ctrl_o),
        .mux_ctrl_o(mux_ctrl_o), .core_en(core_en), .irq(irq), .dma_req(dma_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic set_cmp(input logic v);
        @(negedge clk);
        cmp_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 8; i++) rd_check("R1", 3'(i), 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 dma", {7'b0, dma_req}, 8'h00);
        check("R1 core_en", {7'b0, core_en}, 8'h00);
    endtask

    task automatic t_masks;
        for (int i = 0; i < 8; i++) wr(3'(i), 8'hFF);
        rd_check("R3 off0", 3'd0, 8'h73);
        rd_check("R2 R3 off1 both set", 3'd1, 8'h9F);
        rd_check("R10 off2", 3'd2, 8'hFF);
        rd_check("R3 off3", 3'd3, 8'h58);
        rd_check("R10 off4", 3'd4, 8'hFF);
        rd_check("R3 off5", 3'd5, 8'hBF);
        rd_check("R3 off6", 3'd6, 8'h00);
        rd_check("R3 off7", 3'd7, 8'h00);
        check("R10 dac port", dac_ctrl_o, 8'hFF);
        check("R9 equal selects", {7'b0, core_en}, 8'h00);
        wr(3'd5, 8'h08);
        check("R9 distinct selects", {7'b0, core_en}, 8'h01);
        wr(3'd1, 8'h40);
        rd_check("R2 window alone", 3'd1, 8'h40);
        check("R9 enable off", {7'b0, core_en}, 8'h00);
        wr(3'd1, 8'hC1);
        rd_check("R2 sample wins", 3'd1, 8'h81);
        check("R9 enable on", {7'b0, core_en}, 8'h01);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_edges;
        wr(3'd3, 8'h01);
        rd_check("R4 write ignored", 3'd3, 8'h00);
        set_cmp(1'b1);
        rd_check("R4 R5 rise", 3'd3, 8'h05);
        check("R8 dma off", {7'b0, dma_req}, 8'h00);
        set_cmp(1'b0);
        rd_check("R5 fall", 3'd3, 8'h06);
        wr(3'd3, 8'h02);
        rd_check("R6 clear fall", 3'd3, 8'h04);
        wr(3'd3, 8'h00);
        rd_check("R6 zero keeps", 3'd3, 8'h04);
        wr(3'd3, 8'h04);
        rd_check("R6 clear rise", 3'd3, 8'h00);
    endtask

    task automatic t_irq;
        wr(3'd3, 8'h10);
        check("R7 idle", {7'b0, irq}, 8'h00);
        set_cmp(1'b1);
        check("R7 lag", {7'b0, irq}, 8'h00);
        @(negedge clk);
        check("R7 rise irq", {7'b0, irq}, 8'h01);
        wr(3'd3, 8'h14);
        check("R7 hold after clear", {7'b0, irq}, 8'h01);
        @(negedge clk);
        check("R7 drop", {7'b0, irq}, 8'h00);
        wr(3'd3, 8'h08);
        set_cmp(1'b0);
        @(negedge clk);
        check("R7 fall irq", {7'b0, irq}, 8'h01);
        wr(3'd3, 8'h0A);
        @(negedge clk);
        check("R7 fall drop", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_dma;
        wr(3'd3, 8'h40);
        check("R8 no flag", {7'b0, dma_req}, 8'h00);
        set_cmp(1'b1);
        check("R8 flag", {7'b0, dma_req}, 8'h01);
        wr(3'd3, 8'h44);
        check("R8 cleared", {7'b0, dma_req}, 8'h00);
    endtask

    task automatic t_collide;
        @(negedge clk);
        cmp_in = 1'b0; addr = 3'd3; wdata = 8'h42; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_check("R6 set beats clear", 3'd3, 8'h42);
        check("R8 after collide", {7'b0, dma_req}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_edges();
        t_irq();
        t_dma();
        t_collide();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule